// File: doc/BRIEF.md
# Interrupt-Controller Countdown Timer Bank

This block holds a small bank of free-running countdown timers that feed an interrupt controller. Each timer has a reload register whose top bit stops the timer and a live count whose top bit is a toggle flag. A shared tick-enable input drives all timers. Each enabled timer counts down on every tick. When it expires it reloads, flips its toggle flag and sends a one-cycle request pulse to the shared interrupt-source logic. That logic owns vector, priority and routing for the timer interrupts.

Software reaches the timers through a simple synchronous register port. Writes take effect on the clock edge that samples them. Read data is registered and appears one cycle after the read strobe. A global frequency-report register holds a reset value chosen by a parameter and can be rewritten by software.

Top module: `tmr_bank`

## Requirements
- R1: After reset every live count reads 0 with toggle clear, every reload register reads 0x8000_0000 (stop bit 31 set), the frequency register reads the `FREQ_RESET` parameter and no request is raised.
- R2: While bit 31 of a timer's reload register is 1, ticks change neither its count nor its toggle, and it raises no request.
- R3: A reload write that changes bit 31 from 1 to 0 loads bits 30:0 of the written value into the count. A reload write while the timer already runs leaves the count alone. Each tick on a running timer lowers the count by one.
- R4: A tick that finds a running count at 1 or 0 reloads bits 30:0 of the reload register, inverts the toggle (bit 31 of the live-count read) and raises that timer's `irq` bit for exactly the next cycle. A reload value of N ≥ 1 therefore gives one request every N ticks.
- R5: A reload write clears the toggle only if the toggle is 1, the old bit 31 is 1 and the new bit 31 is 0. In every other case a reload write keeps the toggle.
- R6: Writes to the live-count offset change nothing.
- R7: Address decode: bit 8 set selects the frequency register. Otherwise bits 7:6 pick the timer and bits 5:4 pick the register: 0 live count, 1 reload, 2 and 3 belong to the shared source logic, read as 0 and ignore writes.
- R8: The frequency register stores any written 32-bit value and returns it on read.
- R9: `rdata` carries the addressed value in the cycle after `rd_en`, and is 0 in a cycle that follows no read.
- R10: When a reload write and a tick reach the same timer in the same cycle, the write alone acts and the tick is dropped for that timer.
- R11: Timers are independent: each one's count and requests depend only on its own reload register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count enable shared by all timers |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Register address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |
| irq | output | N_TMR | One-cycle expiry request per timer |

## Verification
A software reload write and a count tick can reach the same timer in the same cycle. The bench forces this twice on one timer. The first time, the write releases the stop bit while a tick is present, and the count must read back the written value rather than one less. The second time, the write sets the stop bit exactly on the tick that would have expired the timer. There the count must stay at 1, the toggle must stay clear and no request may appear.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  // register class selected by an address
  typedef enum logic [1:0] {
    RK_CUR  = 2'd0,
    RK_BASE = 2'd1,
    RK_RSVD = 2'd2,
    RK_FREQ = 2'd3
  } reg_kind_e;

  localparam int OFS_LSB = 4;   // register offset field addr[5:4]
  localparam int GRP_LSB = 6;   // timer index field starts at addr[6]
  localparam logic [1:0] OFS_CUR  = 2'd0;
  localparam logic [1:0] OFS_BASE = 2'd1;
endpackage

// File: rtl/tmr_regdec.sv
module tmr_regdec
  import tmr_pkg::*;
#(
  parameter int N_TMR  = 4,
  parameter int ADDR_W = 9,
  localparam int IDX_W = (N_TMR > 1) ? $clog2(N_TMR) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_kind_e         kind,
  output logic [IDX_W-1:0]  idx
);
  logic       in_range;
  logic [1:0] ofs;

  assign idx = addr[GRP_LSB +: IDX_W];
  assign ofs = addr[OFS_LSB +: 2];

  generate
    if ((2 ** IDX_W) == N_TMR) begin : g_full
      assign in_range = 1'b1;
    end else begin : g_part
      assign in_range = (32'(idx) < N_TMR);
    end
  endgenerate

  always_comb begin
    if (addr[ADDR_W-1])       kind = RK_FREQ;
    else if (!in_range)       kind = RK_RSVD;
    else if (ofs == OFS_CUR)  kind = RK_CUR;
    else if (ofs == OFS_BASE) kind = RK_BASE;
    else                      kind = RK_RSVD;
  end
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit #(
  parameter int DATA_W = 32,
  localparam int CNT_W = DATA_W - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              base_we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] base_q,
  output logic [CNT_W-1:0]  cnt_q,
  output logic              tog_q,
  output logic              irq_q
);
  localparam logic [DATA_W-1:0] BASE_RST = {1'b1, {CNT_W{1'b0}}};

  logic stopped, releasing, expiring;

  assign stopped   = base_q[CNT_W];
  assign releasing = stopped & ~wdata[CNT_W];
  assign expiring  = (cnt_q <= CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= BASE_RST;
      cnt_q  <= '0;
      tog_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (base_we) begin
        // software write owns this cycle; any tick is dropped
        base_q <= wdata;
        if (releasing) begin
          cnt_q <= wdata[CNT_W-1:0];
          tog_q <= 1'b0;   // only changes if it was set
        end
      end else if (tick && !stopped) begin
        if (expiring) begin
          cnt_q <= base_q[CNT_W-1:0];
          tog_q <= ~tog_q;
          irq_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q - CNT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
  import tmr_pkg::*;
#(
  parameter int          N_TMR      = 4,
  parameter int          ADDR_W     = 9,
  parameter int          DATA_W     = 32,
  parameter logic [31:0] FREQ_RESET = 32'd0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [N_TMR-1:0]  irq
);
  localparam int CNT_W = DATA_W - 1;
  localparam int IDX_W = (N_TMR > 1) ? $clog2(N_TMR) : 1;

  reg_kind_e                          kind;
  logic [IDX_W-1:0]                   idx;
  logic [N_TMR-1:0]                   base_we;
  logic [N_TMR-1:0][DATA_W-1:0]       base_v;
  logic [N_TMR-1:0][CNT_W-1:0]        cnt_v;
  logic [N_TMR-1:0]                   tog_v;
  logic [N_TMR-1:0]                   inh_v;
  logic [DATA_W-1:0]                  freq_q;
  logic [DATA_W-1:0]                  rd_mux;

  tmr_regdec #(.N_TMR(N_TMR), .ADDR_W(ADDR_W)) u_dec (
    .addr (addr),
    .kind (kind),
    .idx  (idx)
  );

  generate
    for (genvar g = 0; g < N_TMR; g++) begin : g_tmr
      assign base_we[g] = wr_en && (kind == RK_BASE) && (idx == IDX_W'(g));
      assign inh_v[g]   = base_v[g][CNT_W];

      tmr_unit #(.DATA_W(DATA_W)) u_tmr (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .base_we (base_we[g]),
        .wdata   (wdata),
        .base_q  (base_v[g]),
        .cnt_q   (cnt_v[g]),
        .tog_q   (tog_v[g]),
        .irq_q   (irq[g])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)                               freq_q <= DATA_W'(FREQ_RESET);
    else if (wr_en && (kind == RK_FREQ))   freq_q <= wdata;
  end

  always_comb begin
    rd_mux = '0;
    case (kind)
      RK_CUR:  rd_mux = {tog_v[idx], cnt_v[idx]};
      RK_BASE: rd_mux = base_v[idx];
      RK_FREQ: rd_mux = freq_q;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_en ? rd_mux : '0;
  end
endmodule

// File: rtl/tmr_bank_chk.sv
module tmr_bank_chk #(
  parameter int N_TMR = 4,
  parameter int CNT_W = 31
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       tick,
  input logic [N_TMR-1:0]           irq,
  input logic [N_TMR-1:0]           base_we,
  input logic [N_TMR-1:0]           inh_v,
  input logic [N_TMR-1:0]           tog_v,
  input logic [N_TMR-1:0][CNT_W-1:0] cnt_v
);
  generate
    for (genvar g = 0; g < N_TMR; g++) begin : g_chk
      p_reset_state_r1: assert property (@(posedge clk)
        $past(rst) |-> (inh_v[g] && !tog_v[g] && (cnt_v[g] == '0) && !irq[g]));

      p_stop_holds_r2: assert property (@(posedge clk) disable iff (rst)
        (inh_v[g] && !base_we[g]) |=> ($stable(cnt_v[g]) && $stable(tog_v[g]) && !irq[g]));

      p_irq_from_tick_r4: assert property (@(posedge clk) disable iff (rst)
        irq[g] |-> ($past(tick) && !$past(inh_v[g]) && !$past(base_we[g])));

      p_irq_flips_tog_r4: assert property (@(posedge clk) disable iff (rst)
        irq[g] |-> !$stable(tog_v[g]));

      p_tog_clear_r5: assert property (@(posedge clk) disable iff (rst)
        ($fell(tog_v[g]) && !irq[g]) |-> ($past(base_we[g]) && $past(inh_v[g]) && !inh_v[g]));

      p_write_wins_r10: assert property (@(posedge clk) disable iff (rst)
        base_we[g] |=> !irq[g]);
    end
  endgenerate
endmodule

bind tmr_bank tmr_bank_chk #(.N_TMR(N_TMR), .CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .tick    (tick),
  .irq     (irq),
  .base_we (base_we),
  .inh_v   (inh_v),
  .tog_v   (tog_v),
  .cnt_v   (cnt_v)
);

// File: tb/tb_tmr_bank.sv
`timescale 1ns/1ps
module tb_tmr_bank;
  localparam logic [31:0] FREQ_RST = 32'd4160000;
  localparam logic [1:0] OP_W = 2'd0, OP_R = 2'd1, OP_T = 2'd2, OP_I = 2'd3;
  localparam int NV = 51;

  // {req[3:0], op[1:0], addr[8:0], data[31:0]}
  localparam logic [46:0] VECS [NV] = '{
    {4'd1,  OP_R, 9'h000, 32'h0000_0000},  // R1 count reset
    {4'd1,  OP_R, 9'h010, 32'h8000_0000},  // R1 reload reset
    {4'd1,  OP_R, 9'h100, 32'h003F_7A00},  // R1 frequency reset
    {4'd1,  OP_R, 9'h050, 32'h8000_0000},  // R1 timer1 reload reset
    {4'd2,  OP_T, 9'h000, 32'd3},          // R2 ticks while stopped
    {4'd2,  OP_R, 9'h000, 32'h0000_0000},
    {4'd2,  OP_I, 9'h000, 32'd0},
    {4'd3,  OP_W, 9'h010, 32'h0000_0005},  // R3 release loads count
    {4'd3,  OP_R, 9'h000, 32'h0000_0005},
    {4'd3,  OP_T, 9'h000, 32'd4},
    {4'd3,  OP_R, 9'h000, 32'h0000_0001},
    {4'd4,  OP_I, 9'h000, 32'd0},
    {4'd4,  OP_T, 9'h000, 32'd1},          // R4 expiry
    {4'd4,  OP_R, 9'h000, 32'h8000_0005},
    {4'd4,  OP_I, 9'h000, 32'd1},
    {4'd4,  OP_T, 9'h000, 32'd5},
    {4'd4,  OP_R, 9'h000, 32'h0000_0005},
    {4'd4,  OP_I, 9'h000, 32'd2},
    {4'd4,  OP_T, 9'h000, 32'd5},
    {4'd4,  OP_R, 9'h000, 32'h8000_0005},
    {4'd4,  OP_I, 9'h000, 32'd3},
    {4'd2,  OP_W, 9'h010, 32'h8000_0005},  // R2 stop keeps toggle
    {4'd2,  OP_R, 9'h000, 32'h8000_0005},
    {4'd2,  OP_T, 9'h000, 32'd3},
    {4'd2,  OP_R, 9'h000, 32'h8000_0005},
    {4'd2,  OP_I, 9'h000, 32'd3},
    {4'd5,  OP_W, 9'h010, 32'h0000_0003},  // R5 release clears toggle
    {4'd5,  OP_R, 9'h000, 32'h0000_0003},
    {4'd5,  OP_R, 9'h010, 32'h0000_0003},
    {4'd3,  OP_W, 9'h010, 32'h0000_0007},  // R3 running write, no reload
    {4'd3,  OP_R, 9'h000, 32'h0000_0003},
    {4'd4,  OP_T, 9'h000, 32'd3},
    {4'd4,  OP_R, 9'h000, 32'h8000_0007},
    {4'd4,  OP_I, 9'h000, 32'd4},
    {4'd5,  OP_W, 9'h010, 32'h0000_0009},  // R5 old stop clear: toggle kept
    {4'd5,  OP_R, 9'h000, 32'h8000_0007},
    {4'd5,  OP_R, 9'h010, 32'h0000_0009},
    {4'd6,  OP_W, 9'h000, 32'h1234_5678},  // R6 live count read-only
    {4'd6,  OP_R, 9'h000, 32'h8000_0007},
    {4'd11, OP_W, 9'h090, 32'h0000_0002},  // R11 timer2 alone
    {4'd11, OP_T, 9'h000, 32'd4},
    {4'd11, OP_I, 9'h002, 32'd2},
    {4'd11, OP_I, 9'h001, 32'd0},
    {4'd11, OP_R, 9'h040, 32'h0000_0000},
    {4'd11, OP_R, 9'h080, 32'h0000_0002},
    {4'd8,  OP_W, 9'h100, 32'h0000_CAFE},  // R8 frequency write
    {4'd8,  OP_R, 9'h100, 32'h0000_CAFE},
    {4'd7,  OP_W, 9'h020, 32'hFFFF_FFFF},  // R7 source-logic offsets
    {4'd7,  OP_R, 9'h020, 32'h0000_0000},
    {4'd7,  OP_R, 9'h030, 32'h0000_0000},
    {4'd7,  OP_R, 9'h0D0, 32'h8000_0000}   // R7 timer3 reload
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [8:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  irq;

  int n_chk = 0;
  int n_bad = 0;
  int irq_cnt [4];
  bit done = 1'b0;

  always #10 clk = ~clk;

  tmr_bank #(.FREQ_RESET(FREQ_RST)) dut (
    .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  always @(negedge clk) begin
    for (int i = 0; i < 4; i++) begin
      if (rst) irq_cnt[i] <= 0;
      else     irq_cnt[i] <= irq_cnt[i] + int'(irq[i]);
    end
  end

  task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d: got 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [8:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic ticks(input int n);
    @(negedge clk); tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(1, 32'(irq), 32'h0);  // R1 no request after reset

    for (int k = 0; k < NV; k++) begin
      logic [3:0]  rq;
      logic [1:0]  op;
      logic [8:0]  a;
      logic [31:0] d;
      {rq, op, a, d} = VECS[k];
      case (op)
        OP_W: wr(a, d);
        OP_R: begin rd(a, v); check(int'(rq), v, d); end
        OP_T: ticks(int'(d));
        default: begin
          @(negedge clk); #1;
          check(int'(rq), 32'(irq_cnt[a[1:0]]), d);
        end
      endcase
    end

    // R9: no read in the following cycle gives zero
    rd(9'h100, v);
    check(9, v, 32'h0000_CAFE);
    @(negedge clk);
    check(9, rdata, 32'h0);

    // R4: request pulse pattern with reload 3 on timer3
    wr(9'h0D0, 32'h0000_0003);
    @(negedge clk); tick = 1'b1;
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      check(4, 32'(irq[3]), (k % 3 == 0) ? 32'd1 : 32'd0);
    end
    tick = 1'b0;

    // R10: release write and tick in the same cycle
    @(negedge clk); wr_en = 1'b1; addr = 9'h050; wdata = 32'h0000_0004; tick = 1'b1;
    @(negedge clk); wr_en = 1'b0; tick = 1'b0;
    rd(9'h040, v);
    check(10, v, 32'h0000_0004);
    ticks(3);
    // R10: stop write on the expiring tick
    @(negedge clk); wr_en = 1'b1; addr = 9'h050; wdata = 32'h8000_0004; tick = 1'b1;
    @(negedge clk); wr_en = 1'b0; tick = 1'b0;
    check(10, 32'(irq[1]), 32'h0);
    rd(9'h040, v);
    check(10, v, 32'h0000_0001);
    @(negedge clk); #1;
    check(10, 32'(irq_cnt[1]), 32'd0);

    // R1: reset in the middle of activity
    @(negedge clk); rst = 1'b1; tick = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0; tick = 1'b0;
    rd(9'h000, v);  check(1, v, 32'h0000_0000);
    rd(9'h100, v);  check(1, v, FREQ_RST);
    rd(9'h090, v);  check(1, v, 32'h8000_0000);
    check(1, 32'(irq), 32'h0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule